// File: doc/BRIEF.md
# Pulse-Echo Timing Sequencer

This block produces the control timing for one transmit/receive line of a single-element ultrasound front end. It can repeat that line on request. Each line walks through six phases in a fixed order:

1. a positive drive pulse;
2. a dead gap;
3. a negative damping pulse;
4. a hold-off delay;
5. an acquisition window;
6. a wait that stretches the line to the programmed repetition period.

Every phase length is an input counted in clock ticks. A phase given zero length takes no time at all.

Host logic raises a one-clock trigger while the sequencer is idle. With continuous operation off, this produces exactly one line. With continuous operation on, it produces a programmed number of back-to-back lines, and a 2-bit line index tags each one. During the acquisition window the block also issues a sample strobe. The strobe repeats every `rate_div + 1` ticks and is aimed at a downstream converter interface. That interface, and any capture memory, sit outside this block.

Top module: `echo_seq`

## Requirements
- R1: After a trigger is taken in an idle clock, the following runs in order from the next clock:
  - `drv_pos` is high for `pos_len` ticks;
  - both drive outputs are low for `gap_len` ticks;
  - `drv_neg` is high for `neg_len` ticks;
  - all outputs except `busy` are low for `dly_len` ticks;
  - `acq_en` is high for `acq_len` ticks.
- R2: `drv_pos` and `drv_neg` are never high in the same clock.
- R3: A phase whose length input is zero occupies no clock; the next non-empty phase follows directly.
- R4: One line lasts max(`period_len`, sum of the five phase lengths, 1) ticks. When the period is shorter than the phases, the next line starts on the clock after the acquisition window ends.
- R5: With `cont_en` low, one trigger produces exactly one line, whatever `rep_count` holds.
- R6: With `cont_en` high, one trigger produces `rep_count` lines back to back; a `rep_count` of zero gives one line.
- R7: A trigger that arrives while `busy` is high has no effect, including one in the last busy clock.
- R8: `line_idx` is 0 during the first line of a sequence and advances by one (modulo 4) at each new line. It holds its last value once idle.
- R9: `smp_stb` is high on the first acquisition tick and then every `rate_div + 1` ticks within the window. It is never high outside the window.
- R10: `busy` is high from the first tick of the first line to the last tick of the last line. No drive, acquisition or strobe output is high while `busy` is low.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sw_trig | input | 1 | One-clock start request, honoured only while idle |
| cont_en | input | 1 | 1: repeat `rep_count` lines; 0: one line per trigger |
| rep_count | input | 8 | Lines per sequence in continuous operation (0 acts as 1) |
| pos_len | input | 8 | Positive pulse length in ticks |
| gap_len | input | 8 | Dead gap length in ticks |
| neg_len | input | 16 | Negative damping pulse length in ticks |
| dly_len | input | 16 | Delay before acquisition in ticks |
| acq_len | input | 16 | Acquisition window length in ticks |
| period_len | input | 24 | Minimum line length in ticks |
| rate_div | input | 8 | Sample strobe divider, strobe every rate_div+1 ticks |
| drv_pos | output | 1 | Positive pulser control |
| drv_neg | output | 1 | Negative (damping) pulser control |
| acq_en | output | 1 | Acquisition window enable |
| smp_stb | output | 1 | Sample strobe inside the window |
| line_idx | output | 2 | Index of the current line in the sequence |
| busy | output | 1 | Sequence in progress |

## Verification
Two events can fall in the same clock: the end of the last line of a sequence, and a new trigger. The bench provokes this by raising `sw_trig` in exactly the final busy tick. It judges the result by requiring `busy` to drop on the next clock, all outputs to stay quiet, and `line_idx` to hold the last line's value for several idle ticks.

A second collision is a line restart that lands directly inside an acquisition window, which happens when only the acquisition phase is non-empty and the period is short. The bench expects the strobe divider to restart on the first tick of the new window rather than continue its old count.

// File: rtl/echo_seq_pkg.sv
`timescale 1ns/1ps
package echo_seq_pkg;
  // Phase encoding: the numeric order 1..5 is the firing order of a line.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_POS  = 3'd1,
    PH_GAP  = 3'd2,
    PH_NEG  = 3'd3,
    PH_DLY  = 3'd4,
    PH_ACQ  = 3'd5,
    PH_WAIT = 3'd6
  } phase_e;

  localparam int unsigned FIRST_TIMED = 1;
  localparam int unsigned LAST_TIMED  = 5;
endpackage

// File: rtl/echo_rate_div.sv
`timescale 1ns/1ps
module echo_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acq_nxt,
  input  logic             acq_cur,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             stb_nxt
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (acq_nxt && (!acq_cur || restart))
      cnt_d = '0;
    else if (acq_cur)
      cnt_d = (cnt_q >= div_cfg) ? '0 : cnt_q + DIV_W'(1);
    else
      cnt_d = cnt_q;
    stb_nxt = acq_nxt && (cnt_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/echo_phase_ctrl.sv
`timescale 1ns/1ps
module echo_phase_ctrl
  import echo_seq_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int GAP_W = 8,
  parameter int NEG_W = 16,
  parameter int DLY_W = 16,
  parameter int ACQ_W = 16,
  parameter int PER_W = 24,
  parameter int CNT_W = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             cont_mode,
  input  logic [CNT_W-1:0] rep_count,
  input  logic [POS_W-1:0] pos_len,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [NEG_W-1:0] neg_len,
  input  logic [DLY_W-1:0] dly_len,
  input  logic [ACQ_W-1:0] acq_len,
  input  logic [PER_W-1:0] period_len,
  output phase_e           ph_nxt,
  output logic             new_cyc,
  output logic [IDX_W-1:0] line_idx
);
  localparam int W01   = (POS_W > GAP_W) ? POS_W : GAP_W;
  localparam int W23   = (NEG_W > DLY_W) ? NEG_W : DLY_W;
  localparam int W03   = (W01 > W23) ? W01 : W23;
  localparam int LEN_W = (W03 > ACQ_W) ? W03 : ACQ_W;

  phase_e           ph_q, ph_d, nxt;
  logic [LEN_W-1:0] pc_q, cur_len;
  logic [PER_W-1:0] per_q;
  logic [PER_W:0]   per_next;
  logic [CNT_W-1:0] done_q;
  logic [CNT_W:0]   total, done_next;
  logic [IDX_W-1:0] idx_q;
  logic [LAST_TIMED:FIRST_TIMED] nz;
  logic ph_done, per_met, start_seq, cyc_end, last_cyc;

  // First non-empty timed phase at or after position 'start'; WAIT if none.
  function automatic phase_e first_nz(input int start,
                                      input logic [LAST_TIMED:FIRST_TIMED] map);
    phase_e r;
    r = PH_WAIT;
    for (int i = LAST_TIMED; i >= FIRST_TIMED; i--)
      if (i >= start && map[i]) r = phase_e'(3'(i));
    return r;
  endfunction

  assign nz = {|acq_len, |dly_len, |neg_len, |gap_len, |pos_len};

  always_comb begin
    case (ph_q)
      PH_POS:  cur_len = LEN_W'(pos_len);
      PH_GAP:  cur_len = LEN_W'(gap_len);
      PH_NEG:  cur_len = LEN_W'(neg_len);
      PH_DLY:  cur_len = LEN_W'(dly_len);
      PH_ACQ:  cur_len = LEN_W'(acq_len);
      default: cur_len = '0;
    endcase
  end

  always_comb begin
    per_next  = {1'b0, per_q} + (PER_W+1)'(1);
    per_met   = per_next >= {1'b0, period_len};
    ph_done   = (ph_q == PH_WAIT) ? per_met : (pc_q == cur_len - LEN_W'(1));
    nxt       = first_nz(int'(ph_q) + 1, nz);
    start_seq = (ph_q == PH_IDLE) && trig;
    cyc_end   = (ph_q != PH_IDLE) && ph_done && (nxt == PH_WAIT) && per_met;
    total     = (cont_mode && rep_count != '0) ? {1'b0, rep_count} : (CNT_W+1)'(1);
    done_next = {1'b0, done_q} + (CNT_W+1)'(1);
    last_cyc  = done_next >= total;
    new_cyc   = start_seq || (cyc_end && !last_cyc);

    if (new_cyc)                           ph_d = first_nz(FIRST_TIMED, nz);
    else if (cyc_end)                      ph_d = PH_IDLE;
    else if (ph_q != PH_IDLE && ph_done)   ph_d = nxt;
    else                                   ph_d = ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      pc_q   <= '0;
      per_q  <= '0;
      done_q <= '0;
      idx_q  <= '0;
    end else begin
      ph_q <= ph_d;

      if (new_cyc || ph_d != ph_q)                 pc_q <= '0;
      else if (ph_q != PH_IDLE && ph_q != PH_WAIT) pc_q <= pc_q + LEN_W'(1);

      if (new_cyc)               per_q <= '0;
      else if (ph_q != PH_IDLE)  per_q <= per_next[PER_W-1:0];

      if (start_seq)    done_q <= '0;
      else if (cyc_end) done_q <= done_next[CNT_W-1:0];

      if (start_seq)    idx_q <= '0;
      else if (new_cyc) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign ph_nxt   = ph_d;
  assign line_idx = idx_q;
endmodule

// File: rtl/echo_seq.sv
`timescale 1ns/1ps
module echo_seq
  import echo_seq_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int GAP_W = 8,
  parameter int NEG_W = 16,
  parameter int DLY_W = 16,
  parameter int ACQ_W = 16,
  parameter int PER_W = 24,
  parameter int CNT_W = 8,
  parameter int DIV_W = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_trig,
  input  logic             cont_en,
  input  logic [CNT_W-1:0] rep_count,
  input  logic [POS_W-1:0] pos_len,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [NEG_W-1:0] neg_len,
  input  logic [DLY_W-1:0] dly_len,
  input  logic [ACQ_W-1:0] acq_len,
  input  logic [PER_W-1:0] period_len,
  input  logic [DIV_W-1:0] rate_div,
  output logic             drv_pos,
  output logic             drv_neg,
  output logic             acq_en,
  output logic             smp_stb,
  output logic [IDX_W-1:0] line_idx,
  output logic             busy
);
  phase_e ph_nxt;
  logic   new_cyc, stb_nxt;

  echo_phase_ctrl #(
    .POS_W(POS_W), .GAP_W(GAP_W), .NEG_W(NEG_W), .DLY_W(DLY_W),
    .ACQ_W(ACQ_W), .PER_W(PER_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .trig(sw_trig), .cont_mode(cont_en),
    .rep_count(rep_count), .pos_len(pos_len), .gap_len(gap_len),
    .neg_len(neg_len), .dly_len(dly_len), .acq_len(acq_len),
    .period_len(period_len), .ph_nxt(ph_nxt), .new_cyc(new_cyc),
    .line_idx(line_idx)
  );

  echo_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .acq_nxt(ph_nxt == PH_ACQ), .acq_cur(acq_en),
    .restart(new_cyc), .div_cfg(rate_div), .stb_nxt(stb_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_pos <= 1'b0;
      drv_neg <= 1'b0;
      acq_en  <= 1'b0;
      smp_stb <= 1'b0;
      busy    <= 1'b0;
    end else begin
      drv_pos <= (ph_nxt == PH_POS);
      drv_neg <= (ph_nxt == PH_NEG);
      acq_en  <= (ph_nxt == PH_ACQ);
      smp_stb <= stb_nxt;
      busy    <= (ph_nxt != PH_IDLE);
    end
  end
endmodule

// File: rtl/echo_seq_chk.sv
`timescale 1ns/1ps
module echo_seq_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_trig,
  input logic             drv_pos,
  input logic             drv_neg,
  input logic             acq_en,
  input logic             smp_stb,
  input logic [IDX_W-1:0] line_idx,
  input logic             busy
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(drv_pos && drv_neg)); // R2
  AST_STB_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> acq_en); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(drv_pos || drv_neg || acq_en || smp_stb)); // R10
  AST_START_BY_TRIG: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(sw_trig)); // R5
  AST_IDX_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> line_idx == '0); // R8
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(line_idx))
      |-> line_idx == IDX_W'($past(line_idx) + 1'b1)); // R8
endmodule

bind echo_seq echo_seq_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/echo_seq_tb_top.sv
`timescale 1ns/1ps
module echo_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        sw_trig;
  logic        cont_en;
  logic [7:0]  rep_count;
  logic [7:0]  pos_len, gap_len, rate_div;
  logic [15:0] neg_len, dly_len, acq_len;
  logic [23:0] period_len;
  logic        drv_pos, drv_neg, acq_en, smp_stb, busy;
  logic [1:0]  line_idx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  echo_seq dut_i (
    .clk(clk), .rst(rst), .sw_trig(sw_trig), .cont_en(cont_en),
    .rep_count(rep_count), .pos_len(pos_len), .gap_len(gap_len),
    .neg_len(neg_len), .dly_len(dly_len), .acq_len(acq_len),
    .period_len(period_len), .rate_div(rate_div), .drv_pos(drv_pos),
    .drv_neg(drv_neg), .acq_en(acq_en), .smp_stb(smp_stb),
    .line_idx(line_idx), .busy(busy)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int line_len(input int s, input int per);
    int l;
    l = (per > s) ? per : s;
    return (l < 1) ? 1 : l;
  endfunction

  // spur: 0 none, 1 mid-sequence trigger, 2 trigger in the final busy tick
  task automatic run_seq(input string tag, input int p, input int g, input int n,
                         input int d, input int a, input int per, input int cnt,
                         input bit cont, input int f, input int spur);
    int s, l, ncyc, tot, o, spur_t;
    @(negedge clk);
    pos_len = 8'(p); gap_len = 8'(g); neg_len = 16'(n); dly_len = 16'(d);
    acq_len = 16'(a); period_len = 24'(per); rep_count = 8'(cnt);
    cont_en = cont; rate_div = 8'(f);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    s = p + g + n + d + a;
    o = p + g + n + d;
    l = line_len(s, per);
    ncyc = (cont && cnt != 0) ? cnt : 1;
    tot = ncyc * l;
    spur_t = (spur == 1) ? tot / 2 : (spur == 2) ? tot - 1 : -1;
    for (int t = 0; t < tot + 3; t++) begin
      int u, e_idx;
      bit e_pos, e_neg, e_acq, e_stb, e_busy;
      if (t < tot) begin
        u = t % l;
        e_pos = u < p;
        e_neg = (u >= p + g) && (u < p + g + n);
        e_acq = (u >= o) && (u < s);
        e_stb = e_acq && (((u - o) % (f + 1)) == 0);
        e_busy = 1'b1;
        e_idx = (t / l) % 4;
      end else begin
        e_pos = 0; e_neg = 0; e_acq = 0; e_stb = 0; e_busy = 0;
        e_idx = (ncyc - 1) % 4;
      end
      chk({tag, " R1 drv_pos"}, int'(drv_pos), int'(e_pos));
      chk({tag, " R1 drv_neg"}, int'(drv_neg), int'(e_neg));
      chk({tag, " R1 acq_en"}, int'(acq_en), int'(e_acq));
      chk({tag, " R2 exclusive drive"}, int'(drv_pos & drv_neg), 0);
      chk({tag, " R9 smp_stb"}, int'(smp_stb), int'(e_stb));
      chk({tag, " R10 busy"}, int'(busy), int'(e_busy));
      chk({tag, " R8 line_idx"}, int'(line_idx), e_idx);
      if (t == spur_t) sw_trig = 1'b1;
      @(negedge clk);
      sw_trig = 1'b0;
    end
  endtask

  initial begin
    rst = 1'b1; sw_trig = 1'b0; cont_en = 1'b0; rep_count = '0;
    pos_len = '0; gap_len = '0; neg_len = '0; dly_len = '0; acq_len = '0;
    period_len = '0; rate_div = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: quiet outputs after reset
    chk("R11 reset outputs", int'({drv_pos, drv_neg, acq_en, smp_stb, busy}), 0);
    chk("R11 reset line_idx", int'(line_idx), 0);

    run_seq("R5 single, count ignored", 3, 2, 4, 3, 6, 30, 5, 1'b0, 1, 0);
    run_seq("R3 all phases empty", 0, 0, 0, 0, 0, 0, 3, 1'b1, 0, 0);
    run_seq("R3 only gap and acq", 0, 3, 0, 0, 5, 0, 2, 1'b1, 2, 0);
    run_seq("R4 period shorter than phases", 2, 1, 3, 2, 4, 5, 3, 1'b1, 0, 0);
    run_seq("R4 restart inside window", 0, 0, 0, 0, 7, 3, 3, 1'b1, 2, 0);
    run_seq("R4 long wait", 1, 1, 1, 1, 2, 25, 2, 1'b1, 3, 0);
    run_seq("R6 zero count gives one", 2, 2, 2, 2, 3, 12, 0, 1'b1, 1, 0);
    run_seq("R6 index wraps", 1, 0, 2, 1, 3, 9, 6, 1'b1, 0, 0);
    run_seq("R7 mid trigger", 2, 3, 2, 1, 4, 16, 3, 1'b1, 1, 1);
    run_seq("R7 last-tick trigger", 2, 1, 2, 1, 5, 14, 2, 1'b1, 4, 2);
    run_seq("R9 divider wide", 1, 1, 1, 1, 12, 0, 2, 1'b1, 4, 0);

    for (int i = 0; i < 40; i++) begin
      run_seq("R1 random",
              int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
              int'($urandom_range(0, 8)), int'($urandom_range(0, 8)),
              int'($urandom_range(0, 12)), int'($urandom_range(0, 60)),
              int'($urandom_range(0, 5)), bit'($urandom_range(0, 1)),
              int'($urandom_range(0, 4)), int'($urandom_range(0, 2)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual still running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule